// File: doc/BRIEF.md
# Drive-Status Serial Lamp Transmitter

This block is the initiator end of a three-wire serial general-purpose I/O link that carries per-drive lamp status to a disk backplane. From a system clock it derives a slow reference clock, and on that clock it sends one data line and one framing (load) line. Every frame carries three status bits for each configured drive: activity, locate and fault. Drives go out in ascending order. Frames follow one another back to back for as long as the block is enabled.

The load line marks the first bit of each frame with a 1. A 4-bit vendor field follows on the load line in the next four bit slots. Data and load change only when the reference clock rises, so a target that samples on the falling edge always sees settled values. The drive count and the clock divider are taken while the block is disabled. The status vectors and the vendor field are taken once per frame, when bit 0 is sent, so a single frame never mixes old and new lamp states.

Top module: `sgpio_status_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, or `en` is low at a clock edge, `sclk_o`, `sload_o` and `sdata_o` are all 0 after that edge. The reset is synchronous.
- R2: Each half of the reference clock lasts H system cycles, where H = max(`cfg_half`, MIN_HALF_DIV). The clock starts low, and its first rising edge follows H clock edges after the first edge at which `en` is high.
- R3: `sdata_o` and `sload_o` change only on the system-clock edge where `sclk_o` rises, so both are stable across every falling edge of `sclk_o`.
- R4: A frame is L = max(3N, 5) bits long, where N is the effective drive count. Bit b with b < 3N carries drive b/3, field b mod 3, in the order activity (0), locate (1), fault (2). Any bit with b >= 3N is 0. Frames repeat with no gap, always restarting at drive 0.
- R5: On the load line, bit 0 of each frame is 1. Bits 1 to 4 carry `vendor_pat[3]`, `[2]`, `[1]` and `[0]` in that order. All later bits are 0.
- R6: The status vectors and `vendor_pat` are sampled at the edge that sends bit 0. A change made later in the frame appears only in the next frame.
- R7: `cfg_drives` and `cfg_half` are latched only at edges where `en` is low. Changes made while `en` is high have no effect on the output.
- R8: The effective drive count N is 1 when `cfg_drives` is 0, MAX_DRIVES when `cfg_drives` exceeds MAX_DRIVES, and `cfg_drives` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low stops the link and opens the configuration latch |
| cfg_drives | input | $clog2(MAX_DRIVES+1) | Requested drive count |
| cfg_half | input | DIV_W | Requested half-period of the reference clock, in system cycles |
| act_i | input | MAX_DRIVES | Activity status, one bit per drive |
| loc_i | input | MAX_DRIVES | Locate status, one bit per drive |
| flt_i | input | MAX_DRIVES | Fault status, one bit per drive |
| vendor_pat | input | 4 | Vendor field sent on the load line |
| sclk_o | output | 1 | Generated reference clock |
| sload_o | output | 1 | Frame marker and vendor field |
| sdata_o | output | 1 | Serial drive status |

## Verification
The assertions assume that `cfg_half` is never 0 once it is clamped. They also assume that MIN_HALF_DIV is at least 1, so each half-period of the reference clock covers at least one system cycle. The load-rise and stability properties assume `en` stays high for the whole of each enabled stretch, and they count a drop of `en` as a legal reason for the outputs to fall. The stimulus always programs the configuration with `en` low. It raises and lowers `en` only at falling clock edges, and it changes the status and vendor inputs only between reference-clock rises. This keeps every input change away from the clock edge that samples it.

// File: rtl/sgpio_tx_pkg.sv
// Shared constants for the drive-status serial transmitter.
// Assumes three status fields per drive and a four-bit vendor field.
package sgpio_tx_pkg;

    localparam int BITS_PER_DRIVE = 3;
    localparam int VENDOR_W       = 4;
    localparam int LOAD_BITS      = VENDOR_W + 1;

    // Field order inside one drive slot; the receiver decodes this order.
    typedef enum logic [1:0] {
        FLD_ACT = 2'd0,
        FLD_LOC = 2'd1,
        FLD_FLT = 2'd2
    } lamp_field_e;

    // Longest frame the block can produce for a given drive capacity.
    function automatic int frame_bits_max(input int max_drives);
        return (BITS_PER_DRIVE * max_drives > LOAD_BITS) ?
               BITS_PER_DRIVE * max_drives : LOAD_BITS;
    endfunction

endpackage

// File: rtl/sgpio_clk_div.sv
// Reference-clock generator.
// Divides the system clock into a square wave whose halves each last half_per
// system cycles. The output starts low. It reports the cycle on which it rises
// so that the rest of the block updates on the same edge.
// Assumes half_per is at least 1 and is constant while run is high.
module sgpio_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_per,
    output logic             sclk,
    output logic             rise
);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             tick;

    // End of a half-period.
    assign tick = run && (cnt_q == half_per - DIV_W'(1));
    assign rise = tick && !sclk_q;
    assign sclk = sclk_q;

    // Half-period counter and clock phase; both clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sgpio_frame_seq.sv
// Bit-position sequencer.
// Counts reference-clock bit slots within a frame of frame_len bits and flags
// the slot that opens a new frame.
// Assumes frame_len is at least 2 and stable while run is high.
module sgpio_frame_seq #(
    parameter int FB_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            step,
    input  logic [FB_W-1:0] frame_len,
    output logic            frame_start
);

    logic [FB_W-1:0] pos_q;

    // Slot zero of the frame coincides with a step.
    assign frame_start = step && (pos_q == '0);

    // Position within the frame, wrapping at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos_q <= '0;
        end else if (step) begin
            if (pos_q == frame_len - FB_W'(1)) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + FB_W'(1);
            end
        end
    end

endmodule

// File: rtl/sgpio_serializer.sv
// Data and load line serializer.
// At the start of a frame it snapshots the status of the active drives and the
// vendor field into shift registers, then shifts one bit per step. Drives at or
// above n_drv pack as zeros, and those zeros also fill any padding bits.
// Assumes n_drv is between 1 and MAX_DRIVES.
module sgpio_serializer
    import sgpio_tx_pkg::*;
#(
    parameter int MAX_DRIVES = 8,
    parameter int CNT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  step,
    input  logic                  frame_start,
    input  logic [CNT_W-1:0]      n_drv,
    input  logic [MAX_DRIVES-1:0] act,
    input  logic [MAX_DRIVES-1:0] loc,
    input  logic [MAX_DRIVES-1:0] flt,
    input  logic [VENDOR_W-1:0]   vendor,
    output logic                  sdata,
    output logic                  sload
);

    localparam int PW = BITS_PER_DRIVE * MAX_DRIVES;

    logic [PW-1:0]       packed_w;
    logic [PW-1:0]       dsr_q;
    logic [VENDOR_W-1:0] lsr_q;
    logic [VENDOR_W-1:0] vend_rev;

    // Interleave the three fields of each drive; inactive drives send zeros.
    for (genvar d = 0; d < MAX_DRIVES; d++) begin : g_pack
        logic live;
        assign live = (CNT_W'(d) < n_drv);
        assign packed_w[BITS_PER_DRIVE*d + int'(FLD_ACT)] = live & act[d];
        assign packed_w[BITS_PER_DRIVE*d + int'(FLD_LOC)] = live & loc[d];
        assign packed_w[BITS_PER_DRIVE*d + int'(FLD_FLT)] = live & flt[d];
    end

    // Vendor field leaves most significant bit first from the LSB end.
    for (genvar v = 0; v < VENDOR_W; v++) begin : g_vrev
        assign vend_rev[v] = vendor[VENDOR_W-1-v];
    end

    // Frame snapshot and per-slot shifting of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dsr_q <= '0;
            lsr_q <= '0;
            sdata <= 1'b0;
            sload <= 1'b0;
        end else if (step) begin
            if (frame_start) begin
                sdata <= packed_w[0];
                dsr_q <= packed_w >> 1;
                sload <= 1'b1;
                lsr_q <= vend_rev;
            end else begin
                sdata <= dsr_q[0];
                dsr_q <= dsr_q >> 1;
                sload <= lsr_q[0];
                lsr_q <= lsr_q >> 1;
            end
        end
    end

endmodule

// File: rtl/sgpio_status_tx.sv
// Drive-status serial transmitter, top level.
// Latches the drive count and the clock divider while disabled, clamping each
// to its legal range. Once enabled, it runs the reference-clock divider, the
// frame sequencer and the serializer continuously.
// Assumes en is synchronous to clk.
module sgpio_status_tx
    import sgpio_tx_pkg::*;
#(
    parameter int MAX_DRIVES   = 8,
    parameter int DIV_W        = 16,
    parameter int MIN_HALF_DIV = 1000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               en,
    input  logic [$clog2(MAX_DRIVES+1)-1:0]    cfg_drives,
    input  logic [DIV_W-1:0]                   cfg_half,
    input  logic [MAX_DRIVES-1:0]              act_i,
    input  logic [MAX_DRIVES-1:0]              loc_i,
    input  logic [MAX_DRIVES-1:0]              flt_i,
    input  logic [3:0]                         vendor_pat,
    output logic                               sclk_o,
    output logic                               sload_o,
    output logic                               sdata_o
);

    localparam int CNT_W = $clog2(MAX_DRIVES + 1);
    localparam int FB_W  = $clog2(frame_bits_max(MAX_DRIVES) + 1);

    logic [CNT_W-1:0] n_q;
    logic [DIV_W-1:0] half_q;
    logic [CNT_W-1:0] n_clamped;
    logic [DIV_W-1:0] half_clamped;
    logic [FB_W-1:0]  span;
    logic [FB_W-1:0]  frame_len;
    logic             rise;
    logic             frame_start;

    // Bring requested settings into their legal ranges.
    always_comb begin
        if (cfg_drives == '0) begin
            n_clamped = CNT_W'(1);
        end else if (cfg_drives > CNT_W'(MAX_DRIVES)) begin
            n_clamped = CNT_W'(MAX_DRIVES);
        end else begin
            n_clamped = cfg_drives;
        end
        half_clamped = (cfg_half < DIV_W'(MIN_HALF_DIV)) ? DIV_W'(MIN_HALF_DIV) : cfg_half;
    end

    // Configuration latch, open only while the link is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= CNT_W'(1);
            half_q <= DIV_W'(MIN_HALF_DIV);
        end else if (!en) begin
            n_q    <= n_clamped;
            half_q <= half_clamped;
        end
    end

    // Frame length: three slots per drive, never shorter than the load field.
    always_comb begin
        span      = FB_W'(BITS_PER_DRIVE) * FB_W'(n_q);
        frame_len = (span < FB_W'(LOAD_BITS)) ? FB_W'(LOAD_BITS) : span;
    end

    sgpio_clk_div #(
        .DIV_W (DIV_W)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en),
        .half_per (half_q),
        .sclk     (sclk_o),
        .rise     (rise)
    );

    sgpio_frame_seq #(
        .FB_W (FB_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (en),
        .step        (rise),
        .frame_len   (frame_len),
        .frame_start (frame_start)
    );

    sgpio_serializer #(
        .MAX_DRIVES (MAX_DRIVES),
        .CNT_W      (CNT_W)
    ) ser_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (en),
        .step        (rise),
        .frame_start (frame_start),
        .n_drv       (n_q),
        .act         (act_i),
        .loc         (loc_i),
        .flt         (flt_i),
        .vendor      (vendor_pat),
        .sdata       (sdata_o),
        .sload       (sload_o)
    );

endmodule

// File: rtl/sgpio_status_tx_chk.sv
// Protocol checker for the drive-status transmitter, observing its ports.
// Assumes MIN_HALF_DIV is at least 1.
module sgpio_status_tx_chk #(
    parameter int DIV_W        = 16,
    parameter int MIN_HALF_DIV = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sclk_o,
    input logic sload_o,
    input logic sdata_o
);

    logic             sclk_d;
    logic [DIV_W:0]   hold_q;

    // Length of the current reference-clock phase, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            hold_q <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (sclk_o != sclk_d) begin
                hold_q <= '0;
            end else if (hold_q != '1) begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    // R1: a stop request silences all three lines.
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> (!sclk_o && !sload_o && !sdata_o));

    // R3: data and load move only together with a rising reference clock.
    a_r3_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(rst_n) && !$rose(sclk_o)) |-> ($stable(sdata_o) && $stable(sload_o)));

    // R5: a frame marker never appears off a rising edge.
    a_r5_load_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sload_o) |-> $rose(sclk_o));

    // R2: the high phase of the reference clock is never shorter than the floor.
    a_r2_half_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && sclk_d && !sclk_o) |-> (hold_q >= (DIV_W+1)'(MIN_HALF_DIV - 1)));

endmodule

bind sgpio_status_tx sgpio_status_tx_chk #(
    .DIV_W        (DIV_W),
    .MIN_HALF_DIV (MIN_HALF_DIV)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .sclk_o  (sclk_o),
    .sload_o (sload_o),
    .sdata_o (sdata_o)
);

// File: tb/sgpio_status_tx_tb_top.sv
// Sweep bench: every drive-count setting (including out-of-range values)
// crossed with several divider settings. Each run is checked against an
// arithmetic model of the frame.
module sgpio_status_tx_tb_top;

    localparam int MAXD = 8;
    localparam int DW   = 8;
    localparam int MINH = 2;
    localparam int CW   = $clog2(MAXD + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [CW-1:0]   cfg_drives = '0;
    logic [DW-1:0]   cfg_half = '0;
    logic [MAXD-1:0] act_i = '0, loc_i = '0, flt_i = '0;
    logic [3:0]      vendor_pat = '0;
    logic            sclk_o, sload_o, sdata_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [MAXD-1:0] sa [2];
    logic [MAXD-1:0] sl [2];
    logic [MAXD-1:0] sf [2];
    logic [3:0]      vp [2];
    logic            rec_d [64];
    logic            rec_l [64];

    always #2.5 clk = ~clk;

    sgpio_status_tx #(
        .MAX_DRIVES   (MAXD),
        .DIV_W        (DW),
        .MIN_HALF_DIV (MINH)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cfg_drives (cfg_drives),
        .cfg_half   (cfg_half),
        .act_i      (act_i),
        .loc_i      (loc_i),
        .flt_i      (flt_i),
        .vendor_pat (vendor_pat),
        .sclk_o     (sclk_o),
        .sload_o    (sload_o),
        .sdata_o    (sdata_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_set(input int s);
        act_i      = sa[s];
        loc_i      = sl[s];
        flt_i      = sf[s];
        vendor_pat = vp[s];
    endtask

    function automatic logic exp_data(input int f, input int b, input int n);
        int d;
        int k;
        if (b >= 3 * n) return 1'b0;
        d = b / 3;
        k = b % 3;
        if (k == 0) return sa[f][d];
        if (k == 1) return sl[f][d];
        return sf[f][d];
    endfunction

    function automatic logic exp_load(input int f, input int b);
        if (b == 0) return 1'b1;
        if (b >= 1 && b <= 4) return vp[f][4 - b];
        return 1'b0;
    endfunction

    task automatic run_case(input int cfg_n, input int cfg_h, input int seed);
        int n, h, len, cyc, rises, first_at, last_rise, per_bad, stab_bad;
        int d_bad, l_bad, d_idx, l_idx, quiet_bad;
        logic ps, pd, pl;
        n   = (cfg_n < 1) ? 1 : ((cfg_n > MAXD) ? MAXD : cfg_n);
        h   = (cfg_h < MINH) ? MINH : cfg_h;
        len = (3 * n < 5) ? 5 : 3 * n;
        sa[0] = 8'(seed * 37 + 5);
        sl[0] = 8'(seed * 91 + 3);
        sf[0] = ~8'(seed * 13);
        vp[0] = 4'(seed);
        sa[1] = ~sa[0] ^ 8'(seed);
        sl[1] = sl[0] ^ 8'hA5;
        sf[1] = sf[0] + 8'd77;
        vp[1] = ~vp[0];

        @(negedge clk);
        en         = 1'b0;
        cfg_drives = CW'(cfg_n);
        cfg_half   = DW'(cfg_h);
        apply_set(0);
        repeat (2) @(negedge clk);
        en = 1'b1;
        // R7: settings changed while running must be ignored.
        cfg_drives = CW'(cfg_n + 3);
        cfg_half   = DW'(cfg_h + 5);

        cyc = 0; rises = 0; first_at = -1; last_rise = 0;
        per_bad = 0; stab_bad = 0;
        ps = 1'b0; pd = 1'b0; pl = 1'b0;
        while (rises < 2 * len) begin
            @(negedge clk);
            cyc++;
            if (sclk_o && !ps) begin
                if (rises == 0) first_at = cyc;
                else if (cyc - last_rise != 2 * h) per_bad++;
                rec_d[rises] = sdata_o;
                rec_l[rises] = sload_o;
                rises++;
                last_rise = cyc;
                if (rises == 2) apply_set(1);
            end else begin
                if (sdata_o != pd || sload_o != pl) stab_bad++;
                if (!sclk_o && ps && (cyc - last_rise != h)) per_bad++;
            end
            ps = sclk_o; pd = sdata_o; pl = sload_o;
        end

        d_bad = 0; l_bad = 0; d_idx = -1; l_idx = -1;
        for (int r = 0; r < 2 * len; r++) begin
            if (rec_d[r] !== exp_data(r / len, r % len, n)) begin
                d_bad++;
                if (d_idx < 0) d_idx = r;
            end
            if (rec_l[r] !== exp_load(r / len, r % len)) begin
                l_bad++;
                if (l_idx < 0) l_idx = r;
            end
        end

        check(first_at == h, "R2 first rise delay", first_at, h);
        check(per_bad == 0, "R2/R7 half-period length", per_bad, 0);
        check(stab_bad == 0, "R3 change outside rise", stab_bad, 0);
        check(d_bad == 0, "R4/R6/R8 data stream first bad bit", d_idx, -1);
        check(l_bad == 0, "R5/R6 load stream first bad bit", l_idx, -1);

        en = 1'b0;
        quiet_bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (sclk_o || sload_o || sdata_o) quiet_bad++;
        end
        check(quiet_bad == 0, "R1 disabled lines low", quiet_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(!sclk_o && !sload_o && !sdata_o, "R1 reset outputs",
              {sclk_o, sload_o, sdata_o}, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(!sclk_o && !sload_o && !sdata_o, "R1 reset dominates enable",
              {sclk_o, sload_o, sdata_o}, 0);
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R4, R8: sweep drive counts, including 0 and values above the limit.
        for (int n = 0; n <= 10; n++) begin
            for (int h = 1; h <= 3; h++) begin
                run_case(n, h, n * 7 + h);
            end
        end
        run_case(15, 2, 99);

        // R1: synchronous reset while the link runs.
        @(negedge clk);
        cfg_drives = CW'(4);
        cfg_half   = DW'(3);
        repeat (2) @(negedge clk);
        en = 1'b1;
        while (!sclk_o) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!sclk_o && !sload_o && !sdata_o, "R1 reset while running",
              {sclk_o, sload_o, sdata_o}, 0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_case(3, 4, 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule